// File: doc/BRIEF.md
# Pin Configuration Freeze Register

This block holds one per-pin freeze word plus a single arming bit on a plain strobe-based register bus. While the arming bit is clear, software writes the freeze word freely. The arming bit cannot be written directly. It is set only by a fixed handshake: three writes with the arming bit at one, zero and one, all carrying the same freeze word, followed by a read. Once armed, the block stays armed until reset.

While armed, every pin whose freeze bit is one has its configuration field write-protected. A companion bank of per-pin configuration fields, one per pin, applies this protection internally. The bank exposes its contents, and the freeze mask is available to neighbouring logic. The freeze word and the arming bit remain readable at all times.

The register layout is as follows. The freeze word occupies bits N_PINS-1:0, and the arming bit sits at bit N_PINS (bit 16 at the default width). Read data is registered: it appears the cycle after the read strobe and holds until the next read.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset, rdata, key_active, lock_mask and every configuration field read as zero, and the handshake state is idle.
- R2: While unarmed, each write loads wdata[N_PINS-1:0] into the freeze word. This includes writes that form part of the handshake. Bit N_PINS of a read returns the arming state, and the lower bits return the freeze word. rdata changes only on the edge that samples rd_en and holds otherwise.
- R3: The handshake is: a write with bit N_PINS = 1, then a write with bit N_PINS = 0, then a write with bit N_PINS = 1, then a read. Completing it sets key_active from the next cycle. The completing read returns bit N_PINS = 0, and later reads return 1.
- R4: If any handshake write carries a freeze word that differs from the one already stored, the handshake aborts, and the following read does not arm.
- R5: A read before the third write, a write with the wrong arming value, or an extra write after the third write aborts the handshake without arming.
- R6: After an abort, the handshake restarts from idle, and a fresh, correct handshake then arms.
- R7: Once armed, the block ignores every write. The freeze word and the arming bit stay unchanged until reset, whatever the arming value written.
- R8: A single write with bit N_PINS = 1 followed by a read does not arm.
- R9: lock_mask equals the freeze word while armed and is zero otherwise. Configuration field i, held in cfg_q[i*CFG_W +: CFG_W], loads the matching cfg_wdata slice when cfg_we[i] is set, unless lock_mask[i] is one.
- R10: A cycle with wr_en and rd_en both high aborts the handshake. The write part still loads the freeze word if the block is unarmed, and the read returns the value from before that edge.
- R11: A configuration write made in the same cycle as the arming read is accepted. Protection takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | N_PINS+1 | Write data: freeze word and arming bit |
| rdata | output | N_PINS+1 | Registered read data |
| key_active | output | 1 | Arming state |
| lock_mask | output | N_PINS | Effective per-pin write protection |
| cfg_we | input | N_PINS | Per-pin configuration write enables |
| cfg_wdata | input | N_PINS*CFG_W | Configuration write data, CFG_W bits per pin |
| cfg_q | output | N_PINS*CFG_W | Configuration field contents |

## Verification
Two functions can land on the same edge: the read that arms the block and a write into the configuration bank. The bench drives both in one cycle with all configuration enables set. It expects every field to take the new data, then repeats the write on the next cycle and expects only the unfrozen pins to change. Register writes and reads also coincide under random stimulus. A per-cycle reference model judges those cycles against R10, so a coinciding pair must abort the handshake, still load the freeze word, and return the pre-edge value.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ONE   = 2'd1,
      SEQ_ZERO  = 2'd2,
      SEQ_ARMED = 2'd3
   } seq_state_e;
endpackage

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
   import cfg_lock_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic rd_en,
   input  logic wr_key,
   input  logic pat_match,
   output logic key_q
);
   seq_state_e state_q, state_d;
   logic       key_set;

   always_comb begin
      state_d = state_q;
      key_set = 1'b0;
      if (!key_q) begin
         if (wr_en && rd_en) begin
            state_d = SEQ_IDLE;
         end else if (wr_en) begin
            case (state_q)
               SEQ_IDLE: state_d = wr_key ? SEQ_ONE : SEQ_IDLE;
               SEQ_ONE:  state_d = (!wr_key && pat_match) ? SEQ_ZERO : SEQ_IDLE;
               SEQ_ZERO: state_d = (wr_key && pat_match) ? SEQ_ARMED : SEQ_IDLE;
               default:  state_d = SEQ_IDLE;
            endcase
         end else if (rd_en) begin
            key_set = (state_q == SEQ_ARMED);
            state_d = SEQ_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         key_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         key_q   <= key_q | key_set;
      end
   end
endmodule

// File: rtl/cfg_lock_bits.sv
module cfg_lock_bits #(
   parameter int N_PINS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [N_PINS-1:0] wr_lock,
   input  logic              key_q,
   output logic              pat_match,
   output logic [N_PINS:0]   rdata,
   output logic [N_PINS-1:0] lock_mask
);
   logic [N_PINS-1:0] lock_q;

   assign pat_match = (wr_lock == lock_q);
   assign lock_mask = key_q ? lock_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '0;
         rdata  <= '0;
      end else begin
         if (wr_en && !key_q) lock_q <= wr_lock;
         if (rd_en)           rdata  <= {key_q, lock_q};
      end
   end
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank #(
   parameter int          N_PINS  = 16,
   parameter int          CFG_W   = 4,
   parameter logic [31:0] CFG_RST = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_PINS-1:0]       lock_mask,
   input  logic [N_PINS-1:0]       cfg_we,
   input  logic [N_PINS*CFG_W-1:0] cfg_wdata,
   output logic [N_PINS*CFG_W-1:0] cfg_q
);
   localparam logic [CFG_W-1:0] FIELD_RST = CFG_RST[CFG_W-1:0];

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      logic [CFG_W-1:0] field_q;
      logic             wr_ok;
      assign wr_ok = cfg_we[i] && !lock_mask[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     field_q <= FIELD_RST;
         else if (wr_ok) field_q <= cfg_wdata[i*CFG_W +: CFG_W];
      end
      assign cfg_q[i*CFG_W +: CFG_W] = field_q;
   end
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg #(
   parameter int N_PINS = 16,
   parameter int CFG_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [N_PINS:0]         wdata,
   output logic [N_PINS:0]         rdata,
   output logic                    key_active,
   output logic [N_PINS-1:0]       lock_mask,
   input  logic [N_PINS-1:0]       cfg_we,
   input  logic [N_PINS*CFG_W-1:0] cfg_wdata,
   output logic [N_PINS*CFG_W-1:0] cfg_q
);
   localparam int KEY_BIT = N_PINS;

   if (N_PINS < 1 || N_PINS > 31) begin : g_bad_pins
      $error("cfg_lock_reg: N_PINS must lie in 1..31");
   end
   if (CFG_W < 1 || CFG_W > 32) begin : g_bad_width
      $error("cfg_lock_reg: CFG_W must lie in 1..32");
   end

   logic pat_match;
   logic key_q;

   cfg_lock_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wr_key    (wdata[KEY_BIT]),
      .pat_match (pat_match),
      .key_q     (key_q)
   );

   cfg_lock_bits #(.N_PINS(N_PINS)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wr_lock   (wdata[N_PINS-1:0]),
      .key_q     (key_q),
      .pat_match (pat_match),
      .rdata     (rdata),
      .lock_mask (lock_mask)
   );

   cfg_lock_bank #(.N_PINS(N_PINS), .CFG_W(CFG_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_mask (lock_mask),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_q     (cfg_q)
   );

   assign key_active = key_q;
endmodule

// File: rtl/cfg_lock_reg_chk.sv
module cfg_lock_reg_chk #(
   parameter int N_PINS = 16,
   parameter int CFG_W  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    rd_en,
   input logic [N_PINS:0]         rdata,
   input logic                    key_active,
   input logic [N_PINS-1:0]       lock_mask,
   input logic [N_PINS*CFG_W-1:0] cfg_q
);
   p_key_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      key_active |=> key_active);

   p_mask_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      key_active |=> $stable(lock_mask));

   p_mask_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !key_active |-> (lock_mask == '0));

   p_arm_by_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_active) |-> ($past(rd_en) && !$past(wr_en)));

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   p_rd_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rdata[N_PINS] == $past(key_active)));

   for (genvar i = 0; i < N_PINS; i++) begin : g_field
      p_field_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
         lock_mask[i] |=> $stable(cfg_q[i*CFG_W +: CFG_W]));
   end
endmodule

bind cfg_lock_reg cfg_lock_reg_chk #(.N_PINS(N_PINS), .CFG_W(CFG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .rdata      (rdata),
   .key_active (key_active),
   .lock_mask  (lock_mask),
   .cfg_q      (cfg_q)
);

// File: tb/cfg_lock_reg_test.sv
`timescale 1ns/1ps
module cfg_lock_reg_test;
   localparam int N  = 16;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [N:0]      wdata = '0;
   logic [N:0]      rdata;
   logic            key_active;
   logic [N-1:0]    lock_mask;
   logic [N-1:0]    cfg_we = '0;
   logic [N*CW-1:0] cfg_wdata = '0;
   logic [N*CW-1:0] cfg_q;

   cfg_lock_reg #(.N_PINS(N), .CFG_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .key_active(key_active),
      .lock_mask(lock_mask), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_q(cfg_q)
   );

   always #2.5 clk = ~clk;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   string req   = "R1";

   logic            key_m;
   logic [N-1:0]    lock_m;
   logic [N:0]      rd_m;
   logic [N*CW-1:0] cfg_m;
   int              st_m;

   task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      check(req, "rdata", 128'(rdata), 128'(rd_m));
      check(req, "key_active", 128'(key_active), 128'(key_m));
      check(req, "lock_mask", 128'(lock_mask), 128'(key_m ? lock_m : '0));
      check(req, "cfg_q", 128'(cfg_q), 128'(cfg_m));
   endtask

   function automatic logic [N*CW-1:0] next_cfg(logic [N*CW-1:0] cur, logic k,
         logic [N-1:0] lk, logic [N-1:0] we, logic [N*CW-1:0] wd);
      logic [N*CW-1:0] r = cur;
      for (int i = 0; i < N; i++)
         if (we[i] && !(k && lk[i])) r[i*CW +: CW] = wd[i*CW +: CW];
      return r;
   endfunction

   function automatic int next_st(int st, logic k, logic wr, logic rd, logic wk, logic match);
      if (k) return st;
      if (wr && rd) return 0;
      if (wr) begin
         case (st)
            0: return wk ? 1 : 0;
            1: return (!wk && match) ? 2 : 0;
            2: return (wk && match) ? 3 : 0;
            default: return 0;
         endcase
      end
      if (rd) return 0;
      return st;
   endfunction

   task automatic cycle(logic wr, logic rd, logic [N:0] wd,
                        logic [N-1:0] we, logic [N*CW-1:0] cwd);
      logic set;
      @(negedge clk);
      wr_en = wr; rd_en = rd; wdata = wd; cfg_we = we; cfg_wdata = cwd;
      set   = !key_m && rd && !wr && (st_m == 3);
      if (rd) rd_m = {key_m, lock_m};
      cfg_m = next_cfg(cfg_m, key_m, lock_m, we, cwd);
      st_m  = next_st(st_m, key_m, wr, rd, wd[N], wd[N-1:0] == lock_m);
      if (wr && !key_m) lock_m = wd[N-1:0];
      key_m = key_m | set;
      @(posedge clk);
      #1;
      check_all();
   endtask

   task automatic wr(logic k, logic [N-1:0] p);
      cycle(1'b1, 1'b0, {k, p}, '0, '0);
   endtask
   task automatic rd();
      cycle(1'b0, 1'b1, '0, '0, '0);
   endtask
   task automatic idle();
      cycle(1'b0, 1'b0, '0, '0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 0; rd_en = 0; wdata = '0; cfg_we = '0; cfg_wdata = '0;
      key_m = 0; lock_m = '0; rd_m = '0; cfg_m = '0; st_m = 0;
      @(posedge clk); @(negedge clk);
      req = "R1";
      check_all();
      rst_n = 1'b1;
   endtask

   task automatic rand_phase(int n);
      for (int i = 0; i < n; i++) begin
         logic [N:0] d;
         d = N'($urandom) | ((N+1)'($urandom % 2) << N);
         if ($urandom % 3 == 0) d[N-1:0] = lock_m;
         cycle(($urandom % 3) == 0, ($urandom % 4) == 0, d,
               N'($urandom), {$urandom, $urandom});
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      do_reset();

      req = "R2"; wr(0, 16'h1234); rd(); idle();
      check("R2", "readback", 128'(rdata), 128'({1'b0, 16'h1234}));
      req = "R8"; wr(1, 16'h00FF); rd(); rd();
      check("R8", "no arm", 128'(key_active), 128'(0));
      req = "R4"; wr(1, 16'h0F0F); wr(0, 16'h0F0E); wr(1, 16'h0F0E); rd(); rd();
      check("R4", "no arm", 128'(key_active), 128'(0));
      req = "R5"; wr(1, 16'h3333); rd(); wr(0, 16'h3333); wr(1, 16'h3333); rd();
      wr(1, 16'h3333); wr(1, 16'h3333); wr(1, 16'h3333); rd();
      wr(1, 16'h4444); wr(0, 16'h4444); wr(1, 16'h4444); wr(1, 16'h4444); rd(); rd();
      check("R5", "no arm", 128'(key_active), 128'(0));
      req = "R10"; wr(1, 16'h5555); wr(0, 16'h5555);
      cycle(1'b1, 1'b1, {1'b1, 16'h5555}, '0, '0); rd(); rd();
      check("R10", "no arm", 128'(key_active), 128'(0));
      cycle(1'b1, 1'b1, {1'b0, 16'h6666}, '0, '0);
      check("R10", "pre-edge read", 128'(rdata[N-1:0]), 128'(16'h5555));
      req = "R2"; rand_phase(600);

      do_reset();
      req = "R6"; wr(1, 16'hA5C3); wr(0, 16'hA5C3); wr(0, 16'hA5C3);
      wr(1, 16'hA5C3); wr(0, 16'hA5C3); wr(1, 16'hA5C3);
      req = "R11"; cycle(1'b0, 1'b1, '0, '1, {16{4'h9}});
      check("R3", "arming read", 128'(rdata[N]), 128'(0));
      check("R6", "armed", 128'(key_active), 128'(1));
      check("R11", "same-cycle write", 128'(cfg_q), 128'({16{4'h9}}));
      cycle(1'b0, 1'b0, '0, '1, {16{4'h6}});
      req = "R3"; rd();
      check("R3", "armed read", 128'(rdata), 128'({1'b1, 16'hA5C3}));
      req = "R7"; wr(0, 16'h0000); wr(1, 16'hFFFF); wr(0, 16'h1111); rd();
      check("R7", "frozen", 128'(rdata), 128'({1'b1, 16'hA5C3}));
      req = "R9"; rand_phase(600);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule